// File: doc/BRIEF.md
# CPU Address Window Decoder

This block maps each 32-bit CPU address onto a downstream target by comparing it with a bank of eight programmable windows. A window is described by a control word and a base word. Some windows also have a pair of remap words. The control word holds the enable, a 4-bit target ID, an 8-bit attribute and the window size minus one in 64 KB units. An address hits a window when the window is enabled and the address bits above the size mask equal the base. The hit returns the window's target ID and attribute. When the window can translate, it also returns the address moved into the remap region. Conventional target codes are DRAM = 0, local device bus = 1, PCI = 3 and PCI Express = 4. The block carries the 4-bit code through without interpreting it.

Software reads and writes the window registers through a plain word-addressed port. Lookups arrive on a valid/ready stream and leave on a second valid/ready stream through one register stage. A lookup is accepted when `lk_valid` and `lk_ready` are both high at a rising edge. `lk_ready` is high whenever the output stage is empty or is being drained in the same cycle. A result that the consumer has not taken, because `res_ready` is low, stays unchanged. While that result is held, `lk_ready` stays low, which pushes the back-pressure upstream.

Top module: `addr_window_decoder`

## Requirements
- R1: The control word (word 0 of a slot) places the enable at bit 0, the target ID at bits 7:4, the attribute at bits 15:8 and the size-minus-one at bits 31:16, counted in 64 KB units. Bits 3:1 read back as zero. The target and attribute of the lowest-numbered hitting window appear on `res_target` and `res_attr`.
- R2: The base word (word 1) keeps bits 31:16 only, and bits 15:0 read back as zero.
- R3: Only windows numbered below `REMAP_WINS` hold remap registers. Remap-low (word 2) keeps bits 31:16 and reads its low half as zero. Remap-high (word 3) stores all 32 bits and has no effect on lookups. On every other window, writes to words 2 and 3 are ignored and reads of them return zero.
- R4: A window hits when its enable is 1 and `((addr ^ base) & ~{size,16'hFFFF}) == 0`. A disabled window never hits.
- R5: A hit on a remap-capable window returns `(remap_lo & ~mask) | (addr & mask)`, where mask is `{size,16'hFFFF}`.
- R6: A hit on a window without remap registers returns the input address unchanged.
- R7: When several windows hit, the one with the lowest index wins.
- R8: When no window hits, `res_miss` is 1, `res_target` and `res_attr` are zero, and `res_addr` equals the input address.
- R9: Reset clears every register, so after reset every read returns zero and every lookup misses.
- R10: Register word address `reg_addr` = {window index, word index}, which gives a byte offset of 16*window + 4*word. Reads are combinational. A write takes effect at the clock edge, and a lookup accepted at that same edge still sees the old contents.
- R11: `lk_ready` equals `!res_valid || res_ready`. An accepted lookup gives `res_valid` on the next cycle. A result held while `res_ready` is low keeps all its fields stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address {window, word} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted when high |
| lk_addr | input | 32 | CPU address to decode |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result when high |
| res_miss | output | 1 | No enabled window matched |
| res_target | output | 4 | Target ID of the winning window |
| res_attr | output | 8 | Attribute of the winning window |
| res_addr | output | 32 | Translated or passed-through address |

## Verification
The assertions assume that every input holds a known value once reset is released. They also assume that the consumer's `res_ready` is the only thing that can stall the output stage. Nothing is assumed about window sizes: the hit and translation rules are defined for any control word. For that reason the random stimulus writes arbitrary control words, including sizes that are not powers of two, and the behavioural model follows the same formulas. The bench drives every input at falling edges and holds it through the next rising edge. This keeps each write, lookup and stall within the one-edge handshake that the assertions expect.

// File: rtl/awd_pkg.sv
package awd_pkg;

  localparam logic [1:0] WORD_CTRL = 2'd0;
  localparam logic [1:0] WORD_BASE = 2'd1;
  localparam logic [1:0] WORD_RLO  = 2'd2;
  localparam logic [1:0] WORD_RHI  = 2'd3;

  // Decoded view of one window, as seen by the match logic.
  typedef struct packed {
    logic        en;
    logic [3:0]  target;
    logic [7:0]  attr;
    logic [15:0] size_m1;
    logic [15:0] base;
    logic        remap_en;
    logic [15:0] remap;
  } win_cfg_t;

endpackage

// File: rtl/awd_window_regs.sv
module awd_window_regs
  import awd_pkg::*;
#(
  parameter bit HAS_REMAP = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_word,
  input  logic [31:0] wdata,
  input  logic [1:0]  rd_word,
  output logic [31:0] rdata,
  output win_cfg_t    cfg
);

  logic        en_q;
  logic [3:0]  tgt_q;
  logic [7:0]  attr_q;
  logic [15:0] size_q;
  logic [15:0] base_q;
  logic [31:0] rlo_rd;
  logic [31:0] rhi_rd;
  logic        unused_bits;

  assign unused_bits = ^wdata[3:1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      tgt_q  <= '0;
      attr_q <= '0;
      size_q <= '0;
      base_q <= '0;
    end else if (wr_en) begin
      if (wr_word == WORD_CTRL) begin
        en_q   <= wdata[0];
        tgt_q  <= wdata[7:4];
        attr_q <= wdata[15:8];
        size_q <= wdata[31:16];
      end
      if (wr_word == WORD_BASE) base_q <= wdata[31:16];
    end
  end

  generate
    if (HAS_REMAP) begin : g_remap
      logic [15:0] rlo_q;
      logic [31:0] rhi_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          rlo_q <= '0;
          rhi_q <= '0;
        end else if (wr_en) begin
          if (wr_word == WORD_RLO) rlo_q <= wdata[31:16];
          if (wr_word == WORD_RHI) rhi_q <= wdata;
        end
      end
      assign rlo_rd       = {rlo_q, 16'h0000};
      assign rhi_rd       = rhi_q;
      assign cfg.remap_en = 1'b1;
      assign cfg.remap    = rlo_q;
    end else begin : g_plain
      assign rlo_rd       = '0;
      assign rhi_rd       = '0;
      assign cfg.remap_en = 1'b0;
      assign cfg.remap    = '0;
    end
  endgenerate

  assign cfg.en      = en_q;
  assign cfg.target  = tgt_q;
  assign cfg.attr    = attr_q;
  assign cfg.size_m1 = size_q;
  assign cfg.base    = base_q;

  always_comb begin
    unique case (rd_word)
      WORD_CTRL: rdata = {size_q, attr_q, tgt_q, 3'b000, en_q};
      WORD_BASE: rdata = {base_q, 16'h0000};
      WORD_RLO:  rdata = rlo_rd;
      default:   rdata = rhi_rd;
    endcase
  end

endmodule

// File: rtl/awd_window_match.sv
module awd_window_match
  import awd_pkg::*;
(
  input  win_cfg_t    cfg,
  input  logic [31:0] addr,
  output logic        hit,
  output logic [31:0] xlat
);

  logic [15:0] keep;

  assign keep = ~cfg.size_m1;
  assign hit  = cfg.en && (((addr[31:16] ^ cfg.base) & keep) == 16'h0000);

  always_comb begin
    if (cfg.remap_en)
      xlat = {(cfg.remap & keep) | (addr[31:16] & cfg.size_m1), addr[15:0]};
    else
      xlat = addr;
  end

endmodule

// File: rtl/awd_pick_lowest.sv
module awd_pick_lowest #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

  assign any = |req;

endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
  import awd_pkg::*;
#(
  parameter int NUM_WIN    = 8,
  parameter int REMAP_WINS = 4,
  localparam int IDX_W     = $clog2(NUM_WIN),
  localparam int REG_AW    = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [31:0]       lk_addr,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_miss,
  output logic [3:0]        res_target,
  output logic [7:0]        res_attr,
  output logic [31:0]       res_addr
);

  win_cfg_t           cfg     [NUM_WIN];
  logic [31:0]        rd_arr  [NUM_WIN];
  logic [31:0]        xlat    [NUM_WIN];
  logic [NUM_WIN-1:0] hit_vec;
  logic               any_hit;
  logic [IDX_W-1:0]   sel_idx;
  logic [IDX_W-1:0]   win_q;
  logic [31:0]        addr_q;
  logic               accept;

  generate
    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
      logic wsel;
      assign wsel = reg_wr_en && (reg_addr[REG_AW-1:2] == IDX_W'(i));

      awd_window_regs #(
        .HAS_REMAP(i < REMAP_WINS)
      ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wsel),
        .wr_word (reg_addr[1:0]),
        .wdata   (reg_wdata),
        .rd_word (reg_addr[1:0]),
        .rdata   (rd_arr[i]),
        .cfg     (cfg[i])
      );

      awd_window_match u_match (
        .cfg  (cfg[i]),
        .addr (lk_addr),
        .hit  (hit_vec[i]),
        .xlat (xlat[i])
      );
    end
  endgenerate

  assign reg_rdata = rd_arr[reg_addr[REG_AW-1:2]];

  awd_pick_lowest #(
    .N     (NUM_WIN),
    .IDX_W (IDX_W)
  ) u_pick (
    .req (hit_vec),
    .any (any_hit),
    .idx (sel_idx)
  );

  assign lk_ready = !res_valid || res_ready;
  assign accept   = lk_valid && lk_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_miss   <= 1'b0;
      res_target <= '0;
      res_attr   <= '0;
      res_addr   <= '0;
      win_q      <= '0;
      addr_q     <= '0;
    end else if (accept) begin
      res_valid  <= 1'b1;
      res_miss   <= !any_hit;
      res_target <= any_hit ? cfg[sel_idx].target : 4'h0;
      res_attr   <= any_hit ? cfg[sel_idx].attr : 8'h00;
      res_addr   <= any_hit ? xlat[sel_idx] : lk_addr;
      win_q      <= sel_idx;
      addr_q     <= lk_addr;
    end else if (res_ready) begin
      res_valid  <= 1'b0;
    end
  end

  // R7: chosen window hits and no lower window does
  a_r7_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    accept && any_hit |->
      hit_vec[sel_idx] && ((hit_vec & ~({NUM_WIN{1'b1}} << sel_idx)) == '0));

  // R11: stalled result holds still
  a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=>
      res_valid && $stable(res_addr) && $stable(res_target)
      && $stable(res_attr) && $stable(res_miss));

  // R11: accepted lookup yields a result next cycle
  a_r11_accept_result: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready |=> res_valid);

  // R8: a miss carries zero target and attribute
  a_r8_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_miss |-> res_target == 4'h0 && res_attr == 8'h00);

  // R6: windows without remap pass the address through
  a_r6_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_miss && (int'(win_q) >= REMAP_WINS) |-> res_addr == addr_q);

endmodule

// File: tb/addr_window_decoder_tb.sv
module addr_window_decoder_tb;

  localparam int NW = 8;
  localparam int RW = 4;
  localparam int AW = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [31:0] lk_addr = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_miss;
  logic [3:0]  res_target;
  logic [7:0]  res_attr;
  logic [31:0] res_addr;

  always #5 clk = ~clk;

  addr_window_decoder #(.NUM_WIN(NW), .REMAP_WINS(RW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
    .lk_ready(lk_ready), .lk_addr(lk_addr), .res_valid(res_valid),
    .res_ready(res_ready), .res_miss(res_miss), .res_target(res_target),
    .res_attr(res_attr), .res_addr(res_addr)
  );

  // behavioural model: register images as software would read them
  logic [31:0] m_ctrl [NW];
  logic [31:0] m_base [NW];
  logic [31:0] m_rlo  [NW];
  logic [31:0] m_rhi  [NW];
  logic        m_v, m_miss;
  logic [3:0]  m_tgt;
  logic [7:0]  m_attr;
  logic [31:0] m_addr;
  int          m_win;
  int          vectors = 0;
  int          errs = 0;
  string       phase = "R9";

  function automatic logic [31:0] m_read(logic [AW-1:0] a);
    int w = int'(a[AW-1:2]);
    case (a[1:0])
      2'd0: return m_ctrl[w];
      2'd1: return m_base[w];
      2'd2: return m_rlo[w];
      default: return m_rhi[w];
    endcase
  endfunction

  task automatic m_reset();
    for (int i = 0; i < NW; i++) begin
      m_ctrl[i] = 0; m_base[i] = 0; m_rlo[i] = 0; m_rhi[i] = 0;
    end
    m_v = 0; m_miss = 0; m_tgt = 0; m_attr = 0; m_addr = 0; m_win = 0;
  endtask

  task automatic m_step();
    logic rdy;
    logic [31:0] mask;
    bit found;
    int w;
    rdy = !m_v || res_ready;
    if (lk_valid && rdy) begin
      found = 0;
      for (int i = 0; i < NW; i++) begin
        mask = {m_ctrl[i][31:16], 16'hFFFF};
        if (!found && m_ctrl[i][0] && (((lk_addr ^ m_base[i]) & ~mask) == 0)) begin
          found = 1;
          m_win = i;
          m_tgt = m_ctrl[i][7:4];
          m_attr = m_ctrl[i][15:8];
          m_addr = (i < RW) ? ((m_rlo[i] & ~mask) | (lk_addr & mask)) : lk_addr;
        end
      end
      if (!found) begin
        m_tgt = 0; m_attr = 0; m_addr = lk_addr; m_win = -1;
      end
      m_miss = !found;
      m_v = 1;
    end else if (res_ready) begin
      m_v = 0;
    end
    if (reg_wr_en) begin
      w = int'(reg_addr[AW-1:2]);
      case (reg_addr[1:0])
        2'd0: m_ctrl[w] = reg_wdata & 32'hFFFF_FFF1;
        2'd1: m_base[w] = reg_wdata & 32'hFFFF_0000;
        2'd2: if (w < RW) m_rlo[w] = reg_wdata & 32'hFFFF_0000;
        default: if (w < RW) m_rhi[w] = reg_wdata;
      endcase
    end
  endtask

  task automatic fail(string req, string fld, logic [31:0] got, logic [31:0] exp);
    $display("FAIL %s (phase %s) %s: got %h expected %h at %0t", req, phase, fld, got, exp, $time);
  endtask

  task automatic check();
    bit bad = 0;
    string rq;
    vectors++;
    if (lk_ready !== (!m_v || res_ready)) begin bad = 1; fail("R11", "lk_ready", 32'(lk_ready), 32'(!m_v || res_ready)); end
    if (res_valid !== m_v) begin bad = 1; fail("R11", "res_valid", 32'(res_valid), 32'(m_v)); end
    if (m_v && res_valid === 1'b1) begin
      if (res_miss !== m_miss) begin bad = 1; fail(m_miss ? "R8" : "R4", "res_miss", 32'(res_miss), 32'(m_miss)); end
      if (res_target !== m_tgt) begin bad = 1; fail(m_miss ? "R8" : "R1", "res_target", 32'(res_target), 32'(m_tgt)); end
      if (res_attr !== m_attr) begin bad = 1; fail(m_miss ? "R8" : "R1", "res_attr", 32'(res_attr), 32'(m_attr)); end
      rq = m_miss ? "R8" : ((m_win < RW) ? "R5" : "R6");
      if (res_addr !== m_addr) begin bad = 1; fail(rq, "res_addr", res_addr, m_addr); end
    end
    if (reg_rdata !== m_read(reg_addr)) begin
      bad = 1;
      case (reg_addr[1:0])
        2'd0: rq = "R1";
        2'd1: rq = "R2";
        default: rq = "R3";
      endcase
      fail(rq, "reg_rdata", reg_rdata, m_read(reg_addr));
    end
    if (bad) errs++;
  endtask

  task automatic cyc(input bit w, input logic [AW-1:0] wa, input logic [31:0] wd,
                     input bit lv, input logic [31:0] la, input bit rr, input logic [AW-1:0] ra);
    reg_wr_en = w;
    reg_addr  = w ? wa : ra;
    reg_wdata = wd;
    lk_valid  = lv;
    lk_addr   = la;
    res_ready = rr;
    @(posedge clk);
    m_step();
    @(negedge clk);
    if (w) reg_addr = ra;
    #1;
    check();
  endtask

  task automatic wr(input int win, input int word, input logic [31:0] d);
    cyc(1, AW'(win * 4 + word), d, 0, 0, 1, AW'(win * 4 + word));
  endtask

  task automatic lk(input logic [31:0] a);
    cyc(0, 0, 0, 1, a, 1, 0);
  endtask

  initial begin
    #(200000 * 10);
    errs++;
    $display("FAIL watchdog: run did not finish in time");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check();  // R9 reset state of outputs
    rst_n = 1'b1;

    // R9: every register reads zero, every lookup misses
    phase = "R9";
    for (int a = 0; a < NW * 4; a++) cyc(0, 0, 0, 1, 32'(a) << 27, 1, AW'(a));

    // R1 R2 R3 R10: field packing and slot layout
    phase = "R10";
    wr(0, 0, 32'h000F_A54F);
    wr(0, 1, 32'h1000_1234);
    wr(0, 2, 32'h8000_ABCD);
    wr(0, 3, 32'hDEAD_BEEF);
    wr(1, 0, 32'h00FF_5931);
    wr(1, 1, 32'h1000_0000);
    wr(1, 2, 32'h4000_0000);
    wr(5, 0, 32'h0000_1E11);
    wr(5, 1, 32'h2000_0000);
    phase = "R3";
    wr(5, 2, 32'hFFFF_0000);
    wr(5, 3, 32'h1234_5678);
    wr(6, 0, 32'h000F_1D11);
    wr(6, 1, 32'h2000_0000);
    wr(7, 0, 32'h003F_0F10);
    wr(7, 1, 32'h3000_0000);

    // R5 R6 R7 R4 R8 lookups
    phase = "R5";  lk(32'h1000_5678);
    phase = "R7";  lk(32'h1050_0000);
    phase = "R6";  lk(32'h2000_1234);
    phase = "R7";  lk(32'h2001_0000);
    phase = "R4";  lk(32'h3000_0000);
    phase = "R8";  lk(32'hF000_0000);

    // R10: write and lookup at the same edge, lookup sees old contents
    phase = "R10";
    cyc(1, AW'(0), 32'h0, 1, 32'h1000_5678, 1, AW'(0));
    lk(32'h1000_5678);

    // R11: back-pressure
    phase = "R11";
    for (int k = 0; k < 40; k++)
      cyc(0, 0, 0, (k % 3) != 2, 32'h1000_0000 + 32'(k) * 32'h0001_1000, (k % 4) == 0, AW'(k));

    // random mixture
    phase = "RND";
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] la;
      int j = $urandom % NW;
      la = ($urandom % 4 == 0) ? $urandom : (m_base[j] ^ ($urandom & 32'h00FF_FFFF));
      cyc(($urandom % 4) == 0, AW'($urandom), $urandom, ($urandom % 3) != 0, la,
          ($urandom % 3) != 0, AW'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

endmodule